// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Controller

This block gates hardware event indications into a single interrupt request for a host processor. Event sources raise bits in a 32-bit pending-status register with one-cycle pulses. Software clears pending bits by writing ones to the status register. A 32-bit enable register decides which pending events may interrupt. Its top bit is a master switch that overrides all the others.

Software never writes the enable register directly. It uses two alias addresses instead. A write to the set alias turns on every enable bit written as one. A write to the clear alias turns off every enable bit written as one. Either alias can therefore change single bits without reading the register first, and both aliases read back the current enables. The request is registered. It always carries the same exception code, so the handler must read the status register to find out which event is pending.

Register addresses on the 2-bit address bus are: 0 for status, 1 for the enable-set alias, 2 for the enable-clear alias, and 3 is unused and reads zero. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is high.

Top module: `irq_gate_ctrl`

## Requirements
- R1: Writing address 1 sets every enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R2: Writing address 2 clears every enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: After reset, the status register, the enable register, the request and the exception code are all zero.
- R4: A one-cycle pulse on event input bit n sets status bit n. Writing 1 to status bit n at address 0 clears it, and writing 0 has no effect.
- R5: If an event pulse and a status clear write hit the same bit in the same cycle, the bit ends up set.
- R6: The request rises one cycle after the state change that makes some status bit in 30:0 and its enable bit both 1 while the master enable is 1. It falls one cycle after that condition ends.
- R7: Enable bit 31 is the master enable. While it is 0, the request stays low whatever the status and the other enables are.
- R8: Bit 31 is never an event source. Status bit 31 always reads 0, and a set master enable with no matching event keeps the request low.
- R9: Reading address 1 or address 2 returns the enable register. Reading address 0 returns the status register. Reading address 3 returns 0.
- R10: The exception code output is 0xA00 while the request is high and 0 while it is low.
- R11: Enable bit 30 gates the ownership-change event, which is event input bit 30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| evt_pulse | input | 31 | One-cycle event pulses; bit 30 is ownership change |
| irq_req | output | 1 | Level interrupt request |
| irq_code | output | 12 | Exception code presented with the request |

## Verification
Any corruption in the enable or status state shows up on the read port in the cycle right after the write or pulse that caused it. The request output shows the same corruption one cycle later. The bench therefore reads every register back right after each change and samples the request both before and after its one-cycle latency. This catches a lost clear priority, a master bit that does not gate, or bit 31 being treated as an event source within two cycles. The same-cycle collision between an event pulse and a clear write is driven deliberately, because a wrong priority would only show up as a missing status bit.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned VEC_W = 12;
  localparam logic [VEC_W-1:0] VEC_CODE = 12'hA00;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_EN_SET = 2'd1,
    SEL_EN_CLR = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_mask,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] en_o
);
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] en_d;
  logic              en_ce;

  // A clear beats a set on the same bit.
  always_comb begin
    en_ce = |(set_mask | clr_mask);
    en_d  = (en_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_mask & ~clr_mask)) |=> ((en_q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask))); // R1
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((en_q & $past(clr_mask)) == '0)); // R2
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned EVT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] clr_mask,
  output logic [EVT_W-1:0] stat_o
);
  logic [EVT_W-1:0] stat_q;
  logic [EVT_W-1:0] stat_d;
  logic             stat_ce;

  // A new event beats a clear of the same bit.
  always_comb begin
    stat_ce = |(evt_i | clr_mask);
    stat_d  = (stat_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R5
  AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~evt_i)) |=> ((stat_q & $past(clr_mask & ~evt_i)) == '0)); // R4
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned EVT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] stat_i,
  input  logic [EVT_W-1:0] ev_en_i,
  input  logic             master_i,
  output logic             irq_o
);
  logic [EVT_W-1:0] match;
  logic             irq_d;
  logic             irq_q;

  for (genvar b = 0; b < EVT_W; b++) begin : g_match
    assign match[b] = stat_i[b] & ev_en_i[b];
  end

  always_comb irq_d = master_i & (|match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_REQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && (|(stat_i & ev_en_i))) |=> irq_q); // R6
  AST_REQ_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !master_i |=> !irq_q); // R7
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-2:0] evt_pulse,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_code
);
  localparam int unsigned EVT_W      = DATA_W - 1;
  localparam int unsigned MASTER_BIT = DATA_W - 1;

  logic              rst_n_s;
  logic [DATA_W-1:0] set_mask, en_clr_mask, en_q;
  logic [EVT_W-1:0]  st_clr_mask, stat_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s)
  );

  always_comb begin
    set_mask    = (bus_we && bus_addr == SEL_EN_SET) ? bus_wdata : '0;
    en_clr_mask = (bus_we && bus_addr == SEL_EN_CLR) ? bus_wdata : '0;
    st_clr_mask = (bus_we && bus_addr == SEL_STATUS) ? bus_wdata[EVT_W-1:0] : '0;
  end

  irq_enable_reg #(.DATA_W(DATA_W)) u_en (
    .clk(clk), .rst_n(rst_n_s), .set_mask(set_mask), .clr_mask(en_clr_mask), .en_o(en_q)
  );

  irq_status_reg #(.EVT_W(EVT_W)) u_stat (
    .clk(clk), .rst_n(rst_n_s), .evt_i(evt_pulse), .clr_mask(st_clr_mask), .stat_o(stat_q)
  );

  irq_req_gen #(.EVT_W(EVT_W)) u_req (
    .clk(clk), .rst_n(rst_n_s), .stat_i(stat_q), .ev_en_i(en_q[EVT_W-1:0]),
    .master_i(en_q[MASTER_BIT]), .irq_o(irq_req)
  );

  always_comb begin
    unique case (bus_addr)
      SEL_STATUS:            bus_rdata = {1'b0, stat_q};
      SEL_EN_SET, SEL_EN_CLR: bus_rdata = en_q;
      default:               bus_rdata = '0;
    endcase
  end

  always_comb irq_code = irq_req ? VEC_CODE : '0;

  AST_REQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req |-> $past(en_q[MASTER_BIT])); // R7
endmodule

// File: tb/irq_gate_ctrl_test.sv
`timescale 1ns/1ps
module irq_gate_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [30:0] evt_pulse;
  logic        irq_req;
  logic [11:0] irq_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 request, 2 code
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  irq_gate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  // Monitor: pops expected items and compares just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = {31'd0, irq_req};
          default: act = {20'd0, irq_code};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [30:0] ev = '0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; evt_pulse = ev;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [30:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.kind = 1; it.exp = {31'd0, e}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_code(input logic [11:0] e, input string tag);
    item_t it;
    it.kind = 2; it.exp = {20'd0, e}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0; evt_pulse = '0;
    repeat (3) @(negedge clk);
    // R3 reset state
    chk_rd(2'd0, 32'h0, "R3 status");
    chk_rd(2'd1, 32'h0, "R3 enable");
    chk_irq(1'b0, "R3 request");
    chk_code(12'h000, "R3 code");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 set alias
    wr(2'd1, 32'h0000_00F0); chk_rd(2'd1, 32'h0000_00F0, "R1 set");
    wr(2'd1, 32'h0);         chk_rd(2'd1, 32'h0000_00F0, "R1 zero write");
    wr(2'd1, 32'h0000_0003); chk_rd(2'd1, 32'h0000_00F3, "R1 accumulate");
    // R9 clear alias and spare read
    chk_rd(2'd2, 32'h0000_00F3, "R9 clear alias read");
    chk_rd(2'd3, 32'h0, "R9 spare read");
    // R2 clear alias
    wr(2'd2, 32'h0000_0030); chk_rd(2'd1, 32'h0000_00C3, "R2 clear");
    wr(2'd2, 32'h0);         chk_rd(2'd1, 32'h0000_00C3, "R2 zero write");

    // R4 status set and clear
    pulse(31'h1);            chk_rd(2'd0, 32'h1, "R4 event sets");
    wr(2'd0, 32'h0);         chk_rd(2'd0, 32'h1, "R4 zero write");
    // R7 master off: bit 0 pending and enabled, no request
    chk_irq(1'b0, "R7 master off");
    chk_irq(1'b0, "R7 master off later");

    // R6 master on: one-cycle latency
    wr(2'd1, 32'h8000_0000);
    chk_irq(1'b0, "R6 latency before");
    chk_irq(1'b1, "R6 asserted");
    chk_code(12'hA00, "R10 code with request");
    wr(2'd0, 32'h1);
    chk_irq(1'b1, "R6 fall latency");
    chk_irq(1'b0, "R6 deasserted");
    chk_code(12'h000, "R10 code idle");
    chk_rd(2'd0, 32'h0, "R4 cleared");

    // R8 master alone raises nothing; status bit 31 stays 0
    wr(2'd2, 32'h7FFF_FFFF); chk_rd(2'd1, 32'h8000_0000, "R8 master only");
    pulse(31'h4000_0000);    chk_rd(2'd0, 32'h4000_0000, "R8 status bit31 zero");
    chk_irq(1'b0, "R8 no match");
    chk_irq(1'b0, "R8 no match later");

    // R11 ownership-change enable
    wr(2'd1, 32'h4000_0000);
    chk_irq(1'b0, "R11 latency");
    chk_irq(1'b1, "R11 ownership request");
    wr(2'd2, 32'h8000_0000);
    chk_irq(1'b1, "R7 fall latency");
    chk_irq(1'b0, "R7 master cleared");
    chk_rd(2'd1, 32'h4000_0000, "R2 master cleared");

    // R5 event and clear collide
    wr(2'd0, 32'h4000_0004, 31'h4);
    chk_rd(2'd0, 32'h0000_0004, "R5 set wins");

    done = 1;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule